// File: doc/BRIEF.md
# Bus Strobe Synchronizer with Skew Qualification

This block brings the three active-low strobes of an asynchronous parallel bus into the core clock domain. The three strobes are one address strobe and two data strobes. Each strobe passes through its own chain of three flip-flops. The output of the second stage is brought out from that same chain, so no second, parallel synchronizer is built. The address strobe also gets a fourth history register, which yields registered one-cycle pulses on its falling and rising edges.

The two data strobes can reach the block at slightly different times. A transfer engine therefore needs one settled view of the pair rather than the first edge that arrives. The qualified data-strobe output takes a new value only after the synchronized pair has held that value for `SKEW_WAIT` consecutive cycles. Any movement inside that window restarts the count. `SKEW_WAIT` is chosen from the clock frequency so that the window covers the worst-case strobe skew. A value of 0 suits slow clocks; in that case the qualified output simply trails the third stage by one register. Every output comes straight from a flip-flop.

Top module: `strobe_sync_top`

## Requirements
- R1: Each strobe passes through three flip-flops. For an input change set up before clock edge k (edge 1), the second-stage output shows the new value after edge k+1 and the third-stage output after edge k+2. Every output of the block is a register output.
- R2: While rstN is low, all synchronizer stages and dsQual read 1 (inactive) and both edge pulses read 0, whatever the inputs.
- R3: A high-to-low change of asN gives asFall high for exactly one cycle, after edge k+3, derived from the third stage and its history register.
- R4: A low-to-high change of asN gives asRise high for exactly one cycle, after edge k+3. asFall and asRise are never high together.
- R5: With SKEW_WAIT = W > 0, a change of both data strobes in the same cycle appears on dsQual after edge k+3+W. This holds for all twelve transitions between the four codes of the pair.
- R6: Let the two data strobes change d cycles apart. When d ≤ W, the intermediate code never appears on dsQual. When d > W, it does appear. In both cases dsQual ends at the final code.
- R7: A data-strobe excursion lasting g cycles before it returns to the qualified code leaves dsQual unchanged when g ≤ W. An excursion with g = W+1 is qualified.
- R8: With SKEW_WAIT = 0, dsQual follows the third stage with one extra register, so a change appears after edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| asN | input | 1 | Asynchronous address strobe, active low |
| dsN | input | NUM_DS | Asynchronous data strobes, active low |
| asSync2 | output | 1 | Address strobe after two stages |
| asSync3 | output | 1 | Address strobe after three stages |
| asFall | output | 1 | One-cycle pulse on address strobe assertion |
| asRise | output | 1 | One-cycle pulse on address strobe release |
| dsSync2 | output | NUM_DS | Data strobes after two stages |
| dsSync3 | output | NUM_DS | Data strobes after three stages |
| dsQual | output | NUM_DS | Skew-qualified data strobe pair |

## Verification
The properties assume that each strobe input is a level that stays constant from one clock edge to the next, so that each change is sampled cleanly by the first stage. The edge-pulse and qualification checks rely on this. The stimulus changes inputs only on the falling clock edge and holds every value for whole cycles. It emulates skew and glitches as whole-cycle offsets, sweeping the offset and the glitch width across the wait window and one step beyond it.

// File: rtl/strobe_sync_pkg.sv
package strobe_sync_pkg;
  // Control-to-datapath strobes
  typedef struct packed {
    logic loadQual;
  } qual_ctl_t;
endpackage

// File: rtl/strobe_sync_path.sv
module strobe_sync_path
  import strobe_sync_pkg::*;
#(
  parameter int NUM_DS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              asN,
  input  logic [NUM_DS-1:0] dsN,
  input  qual_ctl_t         qualCtl,
  output logic              asSync2,
  output logic              asSync3,
  output logic              asFall,
  output logic              asRise,
  output logic [NUM_DS-1:0] dsSync2,
  output logic [NUM_DS-1:0] dsSync3,
  output logic [NUM_DS-1:0] dsQual
);
  localparam int LANES = NUM_DS + 1;
  localparam int AS_LANE = NUM_DS;

  logic [LANES-1:0] rawIn;
  logic [LANES-1:0] stage1, stage2, stage3;
  logic asHist;

  assign rawIn = {asN, dsN};

  // One discrete three-flop chain per strobe lane
  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage1[lane] <= 1'b1;
        stage2[lane] <= 1'b1;
        stage3[lane] <= 1'b1;
      end else begin
        stage1[lane] <= rawIn[lane];
        stage2[lane] <= stage1[lane];
        stage3[lane] <= stage2[lane];
      end
    end
  end

  // Edge pulses and qualified pair, all registered
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      asHist <= 1'b1;
      asFall <= 1'b0;
      asRise <= 1'b0;
      dsQual <= '1;
    end else begin
      asHist <= stage3[AS_LANE];
      asFall <= asHist & ~stage3[AS_LANE];
      asRise <= ~asHist & stage3[AS_LANE];
      if (qualCtl.loadQual) dsQual <= stage3[NUM_DS-1:0];
    end
  end

  assign asSync2 = stage2[AS_LANE];
  assign asSync3 = stage3[AS_LANE];
  assign dsSync2 = stage2[NUM_DS-1:0];
  assign dsSync3 = stage3[NUM_DS-1:0];
endmodule

// File: rtl/strobe_skew_ctrl.sv
module strobe_skew_ctrl
  import strobe_sync_pkg::*;
#(
  parameter int NUM_DS    = 2,
  parameter int SKEW_WAIT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_DS-1:0] dsStage3,
  input  logic [NUM_DS-1:0] dsQualNow,
  output qual_ctl_t         qualCtl
);
  if (SKEW_WAIT == 0) begin : g_direct
    assign qualCtl.loadQual = 1'b1;
  end else begin : g_window
    localparam int CNT_W = (SKEW_WAIT < 2) ? 1 : $clog2(SKEW_WAIT);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SKEW_WAIT - 1);

    logic [NUM_DS-1:0] dsHist;
    logic [CNT_W-1:0] waitCnt;
    logic moved, pending, loadNow;

    assign moved   = dsStage3 != dsHist;
    assign pending = dsStage3 != dsQualNow;
    assign loadNow = pending && !moved && (waitCnt == LAST);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dsHist  <= '1;
        waitCnt <= '0;
      end else begin
        dsHist <= dsStage3;
        if (moved || !pending || loadNow) waitCnt <= '0;
        else waitCnt <= waitCnt + 1'b1;
      end
    end

    assign qualCtl.loadQual = loadNow;
  end
endmodule

// File: rtl/strobe_sync_top.sv
module strobe_sync_top
  import strobe_sync_pkg::*;
#(
  parameter int NUM_DS    = 2,
  parameter int SKEW_WAIT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              asN,
  input  logic [NUM_DS-1:0] dsN,
  output logic              asSync2,
  output logic              asSync3,
  output logic              asFall,
  output logic              asRise,
  output logic [NUM_DS-1:0] dsSync2,
  output logic [NUM_DS-1:0] dsSync3,
  output logic [NUM_DS-1:0] dsQual
);
  qual_ctl_t qualCtl;

  strobe_sync_path #(.NUM_DS(NUM_DS)) u_path (
    .clk(clk), .rstN(rstN), .asN(asN), .dsN(dsN), .qualCtl(qualCtl),
    .asSync2(asSync2), .asSync3(asSync3), .asFall(asFall), .asRise(asRise),
    .dsSync2(dsSync2), .dsSync3(dsSync3), .dsQual(dsQual)
  );

  strobe_skew_ctrl #(.NUM_DS(NUM_DS), .SKEW_WAIT(SKEW_WAIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .dsStage3(dsSync3), .dsQualNow(dsQual),
    .qualCtl(qualCtl)
  );
endmodule

// File: rtl/strobe_sync_chk.sv
module strobe_sync_chk #(
  parameter int NUM_DS    = 2,
  parameter int SKEW_WAIT = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              asSync2,
  input logic              asSync3,
  input logic              asFall,
  input logic              asRise,
  input logic [NUM_DS-1:0] dsSync2,
  input logic [NUM_DS-1:0] dsSync3,
  input logic [NUM_DS-1:0] dsQual
);
  // R1
  as_chain_chk: assert property (@(posedge clk) disable iff (!rstN)
    asSync3 == $past(asSync2));
  // R1
  ds_chain_chk: assert property (@(posedge clk) disable iff (!rstN)
    dsSync3 == $past(dsSync2));
  // R3
  fall_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    asFall |=> !asFall);
  // R3
  fall_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    asFall |-> (!$past(asSync3) && $past(asSync3, 2)));
  // R4
  rise_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    asRise |=> !asRise);
  // R4
  rise_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    asRise |-> ($past(asSync3) && !$past(asSync3, 2)));
  // R4
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(asFall && asRise));
  // R5
  qual_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dsQual) |-> dsQual == $past(dsSync3));
  if (SKEW_WAIT > 0) begin : g_hold
    // R6
    qual_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(dsQual) |-> dsQual == $past(dsSync3, 2));
  end
endmodule

bind strobe_sync_top strobe_sync_chk #(.NUM_DS(NUM_DS), .SKEW_WAIT(SKEW_WAIT)) u_chk (
  .clk(clk), .rstN(rstN), .asSync2(asSync2), .asSync3(asSync3),
  .asFall(asFall), .asRise(asRise), .dsSync2(dsSync2), .dsSync3(dsSync3),
  .dsQual(dsQual)
);

// File: tb/strobe_sync_top_tb.sv
module strobe_sync_top_tb;
  localparam int W = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic asN = 1'b1;
  logic [1:0] dsN = 2'b11;

  logic asSync2, asSync3, asFall, asRise;
  logic [1:0] dsSync2, dsSync3, dsQual;
  logic zAs2, zAs3, zFall, zRise;
  logic [1:0] zDs2, zDs3, dsQualZ;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  strobe_sync_top #(.NUM_DS(2), .SKEW_WAIT(W)) u_dut (
    .clk(clk), .rstN(rstN), .asN(asN), .dsN(dsN),
    .asSync2(asSync2), .asSync3(asSync3), .asFall(asFall), .asRise(asRise),
    .dsSync2(dsSync2), .dsSync3(dsSync3), .dsQual(dsQual)
  );

  strobe_sync_top #(.NUM_DS(2), .SKEW_WAIT(0)) u_dutZero (
    .clk(clk), .rstN(rstN), .asN(asN), .dsN(dsN),
    .asSync2(zAs2), .asSync3(zAs3), .asFall(zFall), .asRise(zRise),
    .dsSync2(zDs2), .dsSync3(zDs3), .dsQual(dsQualZ)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settleDs(input logic [1:0] v);
    dsN = v;
    repeat (15) tick();
  endtask

  // Address strobe edge: sample after each of five edges
  task automatic asEdge(input logic newVal);
    logic oldVal;
    oldVal = asN;
    asN = newVal;
    for (int i = 1; i <= 5; i++) begin
      tick();
      check("R1 asSync2", asSync2, (i >= 2) ? newVal : oldVal);
      check("R1 asSync3", asSync3, (i >= 3) ? newVal : oldVal);
      check("R3 asFall", asFall, (newVal == 1'b0 && i == 4) ? 1 : 0);
      check("R4 asRise", asRise, (newVal == 1'b1 && i == 4) ? 1 : 0);
    end
  endtask

  // Both data strobes move together; measure latency on both instances
  task automatic dsStep(input logic [1:0] to);
    int firstW, firstZ;
    firstW = 0;
    firstZ = 0;
    dsN = to;
    for (int i = 1; i <= 15; i++) begin
      tick();
      if (firstW == 0 && dsQual == to) firstW = i;
      if (firstZ == 0 && dsQualZ == to) firstZ = i;
      if (i == 2) check("R1 dsSync2", dsSync2, to);
    end
    check("R5 latency", firstW, 4 + W);
    check("R8 zero-wait latency", firstZ, 4);
  endtask

  initial begin
    asN = 1'b0;
    dsN = 2'b00;
    repeat (3) tick();
    // R2: reset dominates low inputs
    check("R2 asSync2", asSync2, 1);
    check("R2 asSync3", asSync3, 1);
    check("R2 dsSync2", dsSync2, 3);
    check("R2 dsSync3", dsSync3, 3);
    check("R2 asFall", asFall, 0);
    check("R2 asRise", asRise, 0);
    check("R2 dsQual", dsQual, 3);
    check("R2 dsQualZ", dsQualZ, 3);
    asN = 1'b1;
    dsN = 2'b11;
    tick();
    rstN = 1'b1;
    repeat (8) tick();

    // R3, R4: address strobe both ways, twice
    for (int rep = 0; rep < 2; rep++) begin
      asEdge(1'b0);
      repeat (3) tick();
      asEdge(1'b1);
      repeat (3) tick();
    end

    // R5, R8: every transition between the four pair codes
    for (int f = 0; f < 4; f++) begin
      for (int t = 0; t < 4; t++) begin
        if (f != t) begin
          settleDs(2'(f));
          dsStep(2'(t));
        end
      end
    end

    // R6: skew sweep across the window
    for (int d = 0; d <= W + 2; d++) begin
      bit saw;
      settleDs(2'b11);
      saw = 0;
      dsN = 2'b10;
      repeat (d) tick();
      dsN = 2'b00;
      repeat (20) begin
        tick();
        if (dsQual == 2'b10) saw = 1;
      end
      check("R6 partial seen", saw, (d > W) ? 1 : 0);
      check("R6 final code", dsQual, 0);
    end

    // R7: excursions of growing width
    for (int g = 1; g <= W + 1; g++) begin
      bit saw;
      settleDs(2'b11);
      saw = 0;
      dsN = 2'b01;
      repeat (g) tick();
      dsN = 2'b11;
      repeat (20) begin
        tick();
        if (dsQual == 2'b01) saw = 1;
      end
      check("R7 excursion qualified", saw, (g > W) ? 1 : 0);
      check("R7 final code", dsQual, 3);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule